// File: doc/BRIEF.md
# Fixed-Point Fractional Vector Multiplier

This block multiplies two 128-bit vectors of signed fractional numbers lane by lane. A format input chooses how each vector is split. The first choice is eight 16-bit lanes, each with a sign bit and 15 fraction bits. The second choice is four 32-bit lanes, each with a sign bit and 31 fraction bits. Every lane value lies in [-1, 1).

The full-precision product is doubled to realign the fraction point. It can then be added to a third accumulator vector, or subtracted from it. The result is brought back to lane width by truncation, or by rounding when that is requested, and is clamped to the lane range.

The block sits in a vector execution pipeline. It accepts one operation per cycle with a valid strobe. The lane multiplies happen in the first stage. The scaling, accumulation, rounding and saturation happen in the second stage. The result appears with its own valid strobe two cycles after the operation was accepted. The block has no stall and no backpressure.

Top module: `fxp_vmul`

## Requirements
- R1: An operation accepted with valid_i high at a rising edge produces valid_o high exactly two rising edges later. valid_o is low two edges after a cycle in which valid_i was low. One operation may be accepted every cycle.
- R2: With fmt_i=0, lane i occupies bits [16i+15:16i]. With fmt_i=1, lane i occupies bits [32i+31:32i]. For op_i=00 (multiply), each lane result is floor(2·a·b / 2^W), where W is the lane width in bits and a, b are the raw two's-complement lane codes. For example, 0x4000·0x4000 gives 0x2000, and 0xFFFF·0x4000 gives 0xFFFF.
- R3: Multiplying the most negative code by itself saturates to the largest positive code: 0x7FFF for 16-bit lanes and 0x7FFFFFFF for 32-bit lanes.
- R4: With rnd_i=1, the value 2^(W-1) is added to the scaled value before truncation. For example, 0x0001·0x4000 gives 1 with rounding and 0 without it, and 0xFFFF·0x4000 gives 0 with rounding.
- R5: op_i=01 adds the scaled product to the accumulator lane. op_i=10 subtracts the scaled product from the accumulator lane. For example, with acc=0x1000 and a=b=0x4000, the results are 0x3000 and 0xF000.
- R6: For accumulate and subtract, saturation is applied only once, to the final sum. The product term is never clamped on its own. For example, acc=0x8000 plus 0x8000·0x8000 gives 0x0000, and acc=0x7FFF minus 0x8000·0x8000 gives 0xFFFF.
- R7: A final sum above or below the lane range is clamped to the largest positive code or the most negative code of that lane width.
- R8: op_i=11 behaves as a plain multiply, and the accumulator input has no effect.
- R9: After reset, valid_o and res_o are zero. When no operation is accepted, res_o holds its last value.
- R10: Lanes are independent: each lane result depends only on the same lane of a_i, b_i and acc_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| fmt_i | input | 1 | Lane format: 0 = 16-bit lanes, 1 = 32-bit lanes |
| op_i | input | 2 | 00 multiply, 01 multiply-add, 10 multiply-subtract, 11 multiply |
| rnd_i | input | 1 | 1 = round to nearest, 0 = truncate |
| a_i | input | 128 | Multiplicand vector |
| b_i | input | 128 | Multiplier vector |
| acc_i | input | 128 | Accumulator vector |
| valid_o | output | 1 | Result strobe |
| res_o | output | 128 | Result vector |

## Verification
The assertions assume that valid_i, fmt_i, op_i and rnd_i carry known values in every cycle after reset. They also assume that the data vectors are known whenever valid_i is high, because the stage registers and the lane checks sample them. The saturation assertion looks only at lane 0 in the 16-bit format, and it relies on the controls being steady across the sampling edge. The stimulus meets these assumptions by changing inputs only on the falling clock edge and by driving every field to a defined value, including in idle cycles. The random phase draws op_i over all four codes, so the reserved code is covered as well.

// File: rtl/fxp_vmul_pkg.sv
package fxp_vmul_pkg;
  typedef enum logic [1:0] {
    OP_MUL = 2'd0,
    OP_MAC = 2'd1,
    OP_MSB = 2'd2,
    OP_RSV = 2'd3
  } op_e;

  typedef enum logic {
    FMT_H = 1'b0,
    FMT_W = 1'b1
  } fmt_e;
endpackage

// File: rtl/fxp_lane_mul.sv
module fxp_lane_mul #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  assign p_o = $signed(a_i) * $signed(b_i);
endmodule

// File: rtl/fxp_lane_post.sv
module fxp_lane_post
  import fxp_vmul_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [1:0]     op_i,
  input  logic           rnd_i,
  input  logic [2*W-1:0] prod_i,
  input  logic [W-1:0]   acc_i,
  output logic [W-1:0]   res_o
);
  localparam int unsigned SW = 2*W + 3;
  localparam logic signed [SW-1:0] SAT_HI   = {{(W+4){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [SW-1:0] SAT_LO   = {{(W+4){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [SW-1:0] RND_HALF = {{(W+3){1'b0}}, 1'b1, {(W-1){1'b0}}};

  logic signed [SW-1:0] scaled, acc_al, sum, sum_r, shr;
  logic [W-1:0] res_d, res_q;

  always_comb begin
    scaled = SW'($signed(prod_i)) <<< 1;
    acc_al = SW'($signed(acc_i)) <<< W;
    case (op_i)
      OP_MAC:  sum = acc_al + scaled;
      OP_MSB:  sum = acc_al - scaled;
      default: sum = scaled;
    endcase
    sum_r = rnd_i ? (sum + RND_HALF) : sum;
    shr   = sum_r >>> W;
    // single clamp on the final value
    if (shr > SAT_HI)      res_d = SAT_HI[W-1:0];
    else if (shr < SAT_LO) res_d = SAT_LO[W-1:0];
    else                   res_d = shr[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   res_q <= '0;
    else if (en_i) res_q <= res_d;
  end

  assign res_o = res_q;

  AST_MUL_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == OP_MUL || op_i == OP_RSV) && !prod_i[2*W-1] |=> !res_o[W-1]); // R2

  AST_ACC_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == OP_MAC || op_i == OP_MSB) && (prod_i == '0) && !rnd_i
    |=> res_o == $past(acc_i)); // R5
endmodule

// File: rtl/fxp_vmul.sv
module fxp_vmul
  import fxp_vmul_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             fmt_i,
  input  logic [1:0]       op_i,
  input  logic             rnd_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic [VEC_W-1:0] acc_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o
);
  localparam int unsigned NH = VEC_W / 16;
  localparam int unsigned NW = VEC_W / 32;
  localparam int unsigned PW = 2 * VEC_W;

  // stage 1: lane products, both formats pack into PW bits
  logic [PW-1:0] prod_h, prod_w, prod_d, prod_q;
  logic [VEC_W-1:0] acc_q;
  logic [1:0] op_q;
  logic rnd_q, fmt_q, v1_q;

  for (genvar i = 0; i < NH; i++) begin : g_mul_h
    fxp_lane_mul #(.W(16)) u_mul (
      .a_i (a_i[i*16 +: 16]),
      .b_i (b_i[i*16 +: 16]),
      .p_o (prod_h[i*32 +: 32])
    );
  end

  for (genvar j = 0; j < NW; j++) begin : g_mul_w
    fxp_lane_mul #(.W(32)) u_mul (
      .a_i (a_i[j*32 +: 32]),
      .b_i (b_i[j*32 +: 32]),
      .p_o (prod_w[j*64 +: 64])
    );
  end

  assign prod_d = (fmt_i == FMT_W) ? prod_w : prod_h;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      acc_q  <= '0;
      op_q   <= OP_MUL;
      rnd_q  <= 1'b0;
      fmt_q  <= FMT_H;
    end else if (valid_i) begin
      prod_q <= prod_d;
      acc_q  <= acc_i;
      op_q   <= op_i;
      rnd_q  <= rnd_i;
      fmt_q  <= fmt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v1_q <= 1'b0;
    else         v1_q <= valid_i;
  end

  // stage 2: scale, accumulate, round, saturate
  logic [VEC_W-1:0] res_h, res_w;
  logic fmt2_q, v2_q;

  for (genvar i = 0; i < NH; i++) begin : g_post_h
    fxp_lane_post #(.W(16)) u_post (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (v1_q),
      .op_i   (op_q),
      .rnd_i  (rnd_q),
      .prod_i (prod_q[i*32 +: 32]),
      .acc_i  (acc_q[i*16 +: 16]),
      .res_o  (res_h[i*16 +: 16])
    );
  end

  for (genvar j = 0; j < NW; j++) begin : g_post_w
    fxp_lane_post #(.W(32)) u_post (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (v1_q),
      .op_i   (op_q),
      .rnd_i  (rnd_q),
      .prod_i (prod_q[j*64 +: 64]),
      .acc_i  (acc_q[j*32 +: 32]),
      .res_o  (res_w[j*32 +: 32])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt2_q <= FMT_H;
      v2_q   <= 1'b0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) fmt2_q <= fmt_q;
    end
  end

  assign valid_o = v2_q;
  assign res_o   = (fmt2_q == FMT_W) ? res_w : res_h;

  AST_LAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o); // R1

  AST_LAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ##1 !valid_o); // R1

  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ##1 $stable(res_o)); // R9

  AST_NEG_ONE_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (fmt_i == FMT_H) && (op_i == OP_MUL)
    && (a_i[15:0] == 16'h8000) && (b_i[15:0] == 16'h8000)
    |=> ##1 (res_o[15:0] == 16'h7FFF)); // R3
endmodule

// File: tb/tb_fxp_vmul.sv
module tb_fxp_vmul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic fmt_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic rnd_i = 1'b0;
  logic [127:0] a_i = '0, b_i = '0, acc_i = '0;
  logic valid_o;
  logic [127:0] res_o;

  int unsigned cyc = 0;
  int checks = 0;
  int fails = 0;
  logic [127:0] last_exp = '0;

  logic [127:0] q_exp[$];
  string        q_tag[$];
  int unsigned  q_cyc[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  fxp_vmul dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .fmt_i(fmt_i),
    .op_i(op_i), .rnd_i(rnd_i), .a_i(a_i), .b_i(b_i), .acc_i(acc_i),
    .valid_o(valid_o), .res_o(res_o)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic fmt, input logic [1:0] op, input logic rnd,
                                         input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    logic [127:0] r;
    logic signed [127:0] x, y, z, s, hi, lo;
    int w;
    r = '0;
    w = fmt ? 32 : 16;
    for (int i = 0; i < 128 / w; i++) begin
      if (fmt) begin
        x = $signed(a[i*32 +: 32]); y = $signed(b[i*32 +: 32]); z = $signed(c[i*32 +: 32]);
      end else begin
        x = $signed(a[i*16 +: 16]); y = $signed(b[i*16 +: 16]); z = $signed(c[i*16 +: 16]);
      end
      s = x * y * 2;
      if (op == 2'd1)      s = (z <<< w) + s;
      else if (op == 2'd2) s = (z <<< w) - s;
      if (rnd) s = s + (128'sd1 <<< (w - 1));
      s = s >>> w;
      hi = (128'sd1 <<< (w - 1)) - 1;
      lo = -(128'sd1 <<< (w - 1));
      if (s > hi) s = hi;
      else if (s < lo) s = lo;
      if (fmt) r[i*32 +: 32] = s[31:0];
      else     r[i*16 +: 16] = s[15:0];
    end
    return r;
  endfunction

  task automatic send(input logic fmt, input logic [1:0] op, input logic rnd,
                      input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                      input logic [127:0] exp, input string tag);
    @(negedge clk);
    valid_i = 1'b1; fmt_i = fmt; op_i = op; rnd_i = rnd;
    a_i = a; b_i = b; acc_i = c;
    q_exp.push_back(exp); q_tag.push_back(tag); q_cyc.push_back(cyc);
    last_exp = exp;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid_i = 1'b0; op_i = 2'd0; rnd_i = 1'b0; fmt_i = 1'b0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && valid_o) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R1 unexpected valid_o", res_o, '0);
        end else begin
          logic [127:0] e;
          string t;
          int unsigned c0;
          e = q_exp.pop_front(); t = q_tag.pop_front(); c0 = q_cyc.pop_front();
          check(res_o === e, t, res_o, e);
          check(cyc == c0 + 2, "R1 latency", 128'(cyc), 128'(c0 + 2));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o === 1'b0 && res_o === '0, "R9 reset", {127'b0, valid_o} | res_o, '0);
    rst_n = 1'b1;
    idle(2);

    // R2 multiply, 16-bit lanes
    send(0, 2'd0, 0, {8{16'h4000}}, {8{16'h4000}}, '0, {8{16'h2000}}, "R2 half*half");
    send(0, 2'd0, 0, {8{16'hFFFF}}, {8{16'h4000}}, '0, {8{16'hFFFF}}, "R2 neg trunc");
    send(0, 2'd0, 0, {8{16'h0001}}, {8{16'h4000}}, '0, {8{16'h0000}}, "R2 small trunc");
    // R4 rounding
    send(0, 2'd0, 1, {8{16'h0001}}, {8{16'h4000}}, '0, {8{16'h0001}}, "R4 round up");
    send(0, 2'd0, 1, {8{16'hFFFF}}, {8{16'h4000}}, '0, {8{16'h0000}}, "R4 round neg");
    // R3 -1 * -1
    send(0, 2'd0, 0, {8{16'h8000}}, {8{16'h8000}}, '0, {8{16'h7FFF}}, "R3 q15");
    send(0, 2'd0, 1, {8{16'h8000}}, {8{16'h8000}}, '0, {8{16'h7FFF}}, "R3 q15 rnd");
    send(1, 2'd0, 0, {4{32'h80000000}}, {4{32'h80000000}}, '0, {4{32'h7FFFFFFF}}, "R3 q31");
    // R5 accumulate
    send(0, 2'd1, 0, {8{16'h4000}}, {8{16'h4000}}, {8{16'h1000}}, {8{16'h3000}}, "R5 madd");
    send(0, 2'd2, 0, {8{16'h4000}}, {8{16'h4000}}, {8{16'h1000}}, {8{16'hF000}}, "R5 msub");
    // R7 clamp
    send(0, 2'd1, 0, {8{16'h4000}}, {8{16'h4000}}, {8{16'h7000}}, {8{16'h7FFF}}, "R7 madd hi");
    send(0, 2'd2, 0, {8{16'h4000}}, {8{16'h4000}}, {8{16'h9000}}, {8{16'h8000}}, "R7 msub lo");
    // R6 single saturation
    send(0, 2'd1, 0, {8{16'h8000}}, {8{16'h8000}}, {8{16'h8000}}, {8{16'h0000}}, "R6 madd");
    send(0, 2'd2, 0, {8{16'h8000}}, {8{16'h8000}}, {8{16'h7FFF}}, {8{16'hFFFF}}, "R6 msub");
    // R8 reserved op
    send(0, 2'd3, 0, {8{16'h4000}}, {8{16'h4000}}, {8{16'h1000}}, {8{16'h2000}}, "R8 op3");
    // 32-bit lanes
    send(1, 2'd0, 0, {4{32'h40000000}}, {4{32'h40000000}}, '0, {4{32'h20000000}}, "R2 q31");
    send(1, 2'd0, 1, {4{32'h00000001}}, {4{32'h40000000}}, '0, {4{32'h00000001}}, "R4 q31");
    send(1, 2'd1, 0, {4{32'h40000000}}, {4{32'h40000000}}, {4{32'h70000000}}, {4{32'h7FFFFFFF}}, "R7 q31 hi");
    send(1, 2'd2, 0, {4{32'h80000000}}, {4{32'h80000000}}, {4{32'h80000000}}, {4{32'h80000000}}, "R7 q31 lo");
    send(1, 2'd1, 0, {4{32'h80000000}}, {4{32'h80000000}}, {4{32'h80000000}}, {4{32'h00000000}}, "R6 q31");
    // R10 mixed lanes
    send(0, 2'd0, 0, {16'h8000, 16'h4000, 16'h0000, 16'hFFFF, 16'h7FFF, 16'h4000, 16'h8000, 16'h0001},
                     {16'h8000, 16'h4000, 16'h7FFF, 16'h4000, 16'h7FFF, 16'hC000, 16'h7FFF, 16'h4000}, '0,
                     {16'h7FFF, 16'h2000, 16'h0000, 16'hFFFF, 16'h7FFE, 16'hE000, 16'h8001, 16'h0000}, "R10 mixed");
    idle(3);

    for (int n = 0; n < 400; n++) begin
      logic f; logic [1:0] o; logic r;
      logic [127:0] a, b, c;
      f = 1'($urandom); o = 2'($urandom); r = 1'($urandom);
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      c = {$urandom, $urandom, $urandom, $urandom};
      if (n % 16 == 0) begin a[15:0] = 16'h8000; b[15:0] = 16'h8000; end
      send(f, o, r, a, b, c, model(f, o, r, a, b, c), "R10 random");
      if (n % 37 == 0) idle(1);
    end
    idle(4);

    // R9 hold: change inputs without valid
    @(negedge clk);
    a_i = '1; b_i = '1; acc_i = '1; op_i = 2'd1; rnd_i = 1'b1; fmt_i = 1'b1;
    repeat (4) @(negedge clk);
    check(res_o === last_exp, "R9 hold", res_o, last_exp);
    check(valid_o === 1'b0, "R1 idle", {127'b0, valid_o}, '0);
    check(q_exp.size() == 0, "R1 drained", 128'(q_exp.size()), '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule